// File: doc/BRIEF.md
# Variable-Latency Memory Request/Acknowledge Link

This block lets a processor core reach a memory whose response time is not fixed, such as on-chip RAM, an external static RAM or a slow serial device. The core pulses or holds `start` together with an address, a direction and write data. A master state machine registers these values, raises a request level towards memory and keeps the address and write data steady until the memory answers with an acknowledge. On a read, the returned word is captured into a holding register when the acknowledge is seen. `busy` is high for as long as an access is in progress, so the core can stall on it.

Two rules prevent one long request from being seen as two transactions:

- The outgoing request is the registered request ANDed with the inverse of the acknowledge, so it falls in the same cycle the acknowledge rises.
- The master will not accept a new access while the acknowledge is still high.

A test responder with a small word store sits on the memory side. Its latency is set from a 4-bit input.

Master states:

- `MST_IDLE` moves to `MST_ACCESS` on the transition "accept", which needs `start` high and acknowledge low.
- `MST_ACCESS` moves back to `MST_IDLE` on the transition "complete", when the acknowledge is sampled high.

Responder states:

- `RSP_IDLE` moves to `RSP_ACK` ("answer now") when a request arrives and the latency is 0.
- `RSP_IDLE` moves to `RSP_COUNT` ("delay") when a request arrives and the latency is not 0.
- `RSP_COUNT` moves to `RSP_ACK` ("answer") when the count reaches 1.
- `RSP_COUNT` moves to `RSP_IDLE` ("abandon") if the request drops early.
- `RSP_ACK` moves to `RSP_IDLE` ("release") on the next cycle.

Top module: `memhs_top`

## Requirements
- R1: After reset, `bus_req`, `busy` and `done` are 0, `rdata` is 0 and every word of the responder store is 0.
- R2: If `start` is sampled high at a clock edge while the master is idle and `bus_ack` is low, then from that edge onward `busy` and `bus_req` are 1 and `bus_addr` shows the presented address.
- R3: While an access waits with `bus_ack` low, `bus_addr`, the write data and the direction stay unchanged.
- R4: With latency L (0 to 15, sampled when the request is first seen), `bus_ack` rises in the (L+2)-th cycle of `busy` and stays high for exactly one cycle.
- R5: `bus_req` is never high in a cycle in which `bus_ack` is high.
- R6: A read completes one cycle after the acknowledge cycle. `busy` lasts exactly L+2 cycles, `rdata` then holds the stored word, and `done` is high for exactly that one cycle.
- R7: A write stores `wdata` at `addr` in the responder and leaves `rdata` unchanged.
- R8: `start` pulsed while `busy` is high is ignored. No further access follows and the store is not modified.
- R9: With `start` held high continuously, `bus_req` stays low for exactly 2 cycles between consecutive accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Core asks for an access |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| latency | input | LAT_W | Responder wait cycles (0..15) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read data |
| bus_req | output | 1 | Gated request level toward memory |
| bus_ack | output | 1 | Acknowledge from memory |
| bus_addr | output | ADDR_W | Address held on the memory side |

## Verification
If the master's state register were wrong, `busy` would have the wrong length. The bench measures it cycle by cycle against L+2, so the error shows within the same access. If the request were not gated, `bus_req` and `bus_ack` would be high together in the acknowledge cycle. The responder would then count a second transaction, which shows up one access later as an extra `busy` period or as a corrupted word on readback. A capture register loaded at the wrong edge shows up as a stale `rdata` when `done` is high.

// File: rtl/memhs_pkg.sv
package memhs_pkg;

    typedef enum logic {
        MST_IDLE   = 1'b0,
        MST_ACCESS = 1'b1
    } mst_state_e;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_COUNT = 2'd1,
        RSP_ACK   = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/memhs_master.sv
module memhs_master
    import memhs_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);

    mst_state_e        state_q, state_d;
    logic              accept;
    logic              complete;
    logic              we_q;
    logic              done_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    // Next-state logic: accept only when idle and the acknowledge has dropped.
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        complete = 1'b0;
        unique case (state_q)
            MST_IDLE: begin
                if (start && !bus_ack) begin
                    accept  = 1'b1;
                    state_d = MST_ACCESS;
                end
            end
            MST_ACCESS: begin
                if (bus_ack) begin
                    complete = 1'b1;
                    state_d  = MST_IDLE;
                end
            end
            default: state_d = MST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MST_IDLE;
        else        state_q <= state_d;
    end

    // Request fields, captured once per access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            we_q    <= wr_en;
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end

    // Read capture and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= complete;
            if (complete && !we_q) rdata_q <= bus_rdata;
        end
    end

    // Outputs.
    always_comb begin
        busy      = (state_q == MST_ACCESS);
        bus_req   = (state_q == MST_ACCESS) && !bus_ack;
        bus_we    = we_q;
        bus_addr  = addr_q;
        bus_wdata = wdata_q;
        done      = done_q;
        rdata     = rdata_q;
    end

    assert_req_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_ack));

    assert_hold_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_req_in_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> busy);

endmodule

// File: rtl/memhs_responder.sv
module memhs_responder
    import memhs_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LAT_W-1:0]  latency,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    rsp_state_e        state_q, state_d;
    logic [LAT_W-1:0]  cnt_q, cnt_d;
    logic              fire;
    logic [DATA_W-1:0] store_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        unique case (state_q)
            RSP_IDLE: begin
                if (req) begin
                    if (latency == '0) begin
                        fire    = 1'b1;
                        state_d = RSP_ACK;
                    end else begin
                        cnt_d   = latency;
                        state_d = RSP_COUNT;
                    end
                end
            end
            RSP_COUNT: begin
                if (!req) begin
                    state_d = RSP_IDLE;
                end else if (cnt_q == LAT_W'(1)) begin
                    fire    = 1'b1;
                    state_d = RSP_ACK;
                end else begin
                    cnt_d = cnt_q - LAT_W'(1);
                end
            end
            RSP_ACK:  state_d = RSP_IDLE;
            default:  state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Word store: the access is carried out at the edge that raises ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) store_q[i] <= '0;
            rdata_q <= '0;
        end else if (fire) begin
            if (we) store_q[addr] <= wdata;
            else    rdata_q       <= store_q[addr];
        end
    end

    always_comb begin
        ack   = (state_q == RSP_ACK);
        rdata = rdata_q;
    end

    assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_ack_after_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(req));

endmodule

// File: rtl/memhs_top.sv
module memhs_top #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LAT_W-1:0]  latency,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_req,
    output logic              bus_ack,
    output logic [ADDR_W-1:0] bus_addr
);

    logic              req_w;
    logic              we_w;
    logic              ack_w;
    logic [ADDR_W-1:0] addr_w;
    logic [DATA_W-1:0] wdata_w;
    logic [DATA_W-1:0] rdata_w;

    memhs_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .busy      (busy),
        .done      (done),
        .rdata     (rdata),
        .bus_req   (req_w),
        .bus_we    (we_w),
        .bus_addr  (addr_w),
        .bus_wdata (wdata_w),
        .bus_ack   (ack_w),
        .bus_rdata (rdata_w)
    );

    memhs_responder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT_W(LAT_W)) u_resp (
        .clk     (clk),
        .rst_n   (rst_n),
        .latency (latency),
        .req     (req_w),
        .we      (we_w),
        .addr    (addr_w),
        .wdata   (wdata_w),
        .ack     (ack_w),
        .rdata   (rdata_w)
    );

    always_comb begin
        bus_req  = req_w;
        bus_ack  = ack_w;
        bus_addr = addr_w;
    end

endmodule

// File: tb/tb_memhs_top.sv
module tb_memhs_top;

    localparam int AW = 4;
    localparam int DW = 16;
    localparam int LW = 4;
    localparam int NV = 8;
    localparam int VW = 1 + AW + DW + LW + DW;

    // Vector layout: {write, addr, wdata, latency, expected read data}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1, 4'd3,  16'hA5A5, 4'd0,  16'h0000},
        {1'b1, 4'd12, 16'h1234, 4'd3,  16'h0000},
        {1'b0, 4'd3,  16'h0000, 4'd0,  16'hA5A5},
        {1'b0, 4'd12, 16'h0000, 4'd15, 16'h1234},
        {1'b1, 4'd0,  16'hFFFF, 4'd1,  16'h0000},
        {1'b0, 4'd0,  16'h0000, 4'd2,  16'hFFFF},
        {1'b1, 4'd15, 16'h0001, 4'd7,  16'h0000},
        {1'b0, 4'd15, 16'h0000, 4'd1,  16'h0001}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [LW-1:0] latency = '0;
    logic          busy, done, bus_req, bus_ack;
    logic [DW-1:0] rdata;
    logic [AW-1:0] bus_addr;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic [DW-1:0] last_rd = '0;

    memhs_top #(.ADDR_W(AW), .DATA_W(DW), .LAT_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .latency(latency), .busy(busy), .done(done), .rdata(rdata),
        .bus_req(bus_req), .bus_ack(bus_ack), .bus_addr(bus_addr)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One access; sampling at negedges. cyc counts busy cycles.
    task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [LW-1:0] lat, input logic [DW-1:0] exp_rd);
        int cyc;
        int ack_at;
        int ack_len;
        logic stable_ok;
        logic gate_ok;
        @(negedge clk);
        start = 1'b1; wr_en = we; addr = a; wdata = d; latency = lat;
        @(negedge clk);
        start = 1'b0; wr_en = ~we; addr = ~a; wdata = ~d;
        check("R2 busy", busy, 1);
        check("R2 bus_req", bus_req, (lat == 0) ? 1 : 1);
        check("R2 bus_addr", bus_addr, a);
        cyc = 1; ack_at = -1; ack_len = 0; stable_ok = 1'b1; gate_ok = 1'b1;
        while (busy && cyc < 40) begin
            if (bus_ack) begin
                if (ack_at < 0) ack_at = cyc;
                ack_len++;
            end
            if (bus_ack && bus_req) gate_ok = 1'b0;
            if (bus_addr !== a) stable_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        check("R3 address held while waiting", stable_ok, 1);
        check("R5 req low during ack", gate_ok, 1);
        check("R4 ack cycle", ack_at, lat + 2);
        check("R4 ack length", ack_len, 1);
        check("R6 busy length", cyc - 1, lat + 2);
        check("R6 done at completion", done, 1);
        if (we) check("R7 rdata unchanged by write", rdata, last_rd);
        else begin
            check("R6 read data", rdata, exp_rd);
            last_rd = exp_rd;
        end
        @(negedge clk);
        check("R6 done one cycle", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 bus_req", bus_req, 0);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 rdata", rdata, 0);
        rst_n = 1'b1;

        access(1'b0, 4'd7, 16'h0, 4'd2, 16'h0000); // R1 store cleared

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][VW-1], VEC[i][VW-2 -: AW], VEC[i][DW+LW+DW-1 -: DW],
                   VEC[i][DW+LW-1 -: LW], VEC[i][DW-1:0]);
        end

        // R8: start pulsed during a busy write is ignored.
        begin
            int busy_after;
            @(negedge clk);
            start = 1'b1; wr_en = 1'b1; addr = 4'd5; wdata = 16'hBEEF; latency = 4'd6;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            start = 1'b1; wr_en = 1'b1; addr = 4'd9; wdata = 16'hDEAD;
            @(negedge clk);
            start = 1'b0;
            while (busy) @(negedge clk);
            busy_after = 0;
            repeat (4) begin
                @(negedge clk);
                if (busy) busy_after++;
            end
            check("R8 no extra access", busy_after, 0);
        end
        access(1'b0, 4'd9, 16'h0, 4'd0, 16'h0000);  // R8 store untouched
        access(1'b0, 4'd5, 16'h0, 4'd4, 16'hBEEF);  // R7 write landed

        // R9: start held high, measure request-low gap.
        begin
            logic prev;
            int fall_at;
            int gaps;
            int cyc;
            @(negedge clk);
            start = 1'b1; wr_en = 1'b0; addr = 4'd3; latency = 4'd1;
            prev = 1'b0; fall_at = -1; gaps = 0; cyc = 0;
            repeat (20) begin
                @(negedge clk);
                cyc++;
                if (prev && !bus_req) fall_at = cyc;
                if (!prev && bus_req && fall_at >= 0) begin
                    check("R9 request gap", cyc - fall_at, 2);
                    gaps++;
                end
                prev = bus_req;
            end
            start = 1'b0;
            check("R9 several back-to-back accesses", (gaps >= 3) ? 1 : 0, 1);
            while (busy) @(negedge clk);
            @(negedge clk);
            check("R9 read data", rdata, 16'hA5A5);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule